// File: doc/BRIEF.md
# Reset-Time Configuration Strap Sampler

This block reads the board-level configuration straps of a serial switch when hard reset is released. The switch has port pairs, and each pair can run as one four-lane port or as two single-lane ports. The straps select five things: the width of each pair, the power-down request of each port, the default line rate, and the lane order for the transmit direction and for the receive direction. A strap set is accepted only after it has held the same value for a run of consecutive register-clock cycles. From that point the values are frozen and later strap activity is ignored.

From the frozen values the block derives a width flag per pair, a powered-down flag per port (with the pair coupling and the forced shutdown of the unused upper port), a two-bit line-rate code, and a physical-lane index map for each direction. After capture, software writes may replace the line rate and the per-port power-down requests. The legality rule and the coupling rule apply to those writes in the same way as to the straps.

Top module: `strap_sampler`

## Requirements
- R1: After reset is released, the strap set is captured at the first rising edge at which it has shown the same value at STABLE_CYCLES consecutive edges (default 10), counting from the first edge after release. Any change restarts the run at 1. `cfg_valid` is 1 from the cycle after that edge.
- R2: Once `cfg_valid` is 1, changes on any strap input have no effect on any output.
- R3: `port_split[p]` equals the captured split strap of pair p: 0 means one four-lane port, 1 means two single-lane ports 2p and 2p+1.
- R4: `port_off[2p]` equals the power-down request of port 2p. In split mode, `port_off[2p+1]` is 1 when the request of port 2p or of port 2p+1 is 1.
- R5: When pair p is in four-lane mode, `port_off[2p+1]` is 1 whatever its own request is.
- R6: `line_speed` encodes 00 = 1.25, 01 = 2.5 and 10 = 3.125 Gbit/s. A captured or written code of 11 yields 10 and sets `speed_err`, which then stays 1 until reset.
- R7: The field at bits [(p*LANES+l)*IDXW +: IDXW] of `tx_lane_map` gives the physical lane that carries logical lane l of pair p. It is l when the transmit swap strap is 0 and LANES-1-l when it is 1.
- R8: `rx_lane_map` uses the same layout, driven by the receive swap strap. A pair in split mode always gets the identity order.
- R9: While `cfg_valid` is 1, `sw_speed_we` loads `sw_speed` and `sw_pwr_we` loads `sw_pwr` as the per-port power-down requests, each one cycle later. Either write is ignored while `cfg_valid` is 0.
- R10: While reset is held, `cfg_valid`, `port_split` and `speed_err` are 0, every `port_off` bit is 1, `line_speed` is 10, and both lane maps are the identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low hard reset, synchronous |
| strap_split | input | NUM_PAIRS | Split strap per pair |
| strap_pwr | input | NUM_PORTS | Power-down strap per port |
| strap_speed | input | 2 | Default line-rate strap |
| strap_tx_rev | input | 1 | Transmit lane reversal strap |
| strap_rx_rev | input | 1 | Receive lane reversal strap |
| sw_speed_we | input | 1 | Software line-rate write strobe |
| sw_speed | input | 2 | Software line-rate value |
| sw_pwr_we | input | 1 | Software power-down write strobe |
| sw_pwr | input | NUM_PORTS | Software power-down requests |
| cfg_valid | output | 1 | Straps captured and frozen |
| port_split | output | NUM_PAIRS | Pair runs as two single-lane ports |
| port_off | output | NUM_PORTS | Port powered down |
| line_speed | output | 2 | Effective line-rate code |
| speed_err | output | 1 | Sticky illegal-rate flag |
| tx_lane_map | output | NUM_PAIRS*LANES*IDXW | Transmit lane index map |
| rx_lane_map | output | NUM_PAIRS*LANES*IDXW | Receive lane index map |

## Verification
Captured values and `cfg_valid` appear one cycle after the rising edge that completes the stable run, so they appear after edge 10 when the straps are steady from release and after edge 14 when a strap changes at edge 4. A software write shows on `line_speed`, `speed_err` or `port_off` one cycle after the strobe edge, and the power and lane-map decodes add no further delay. A behavioural model in the bench advances on each rising edge. Every output is compared with it at the following falling edge, and directed checks sample exactly at the edges named above.

// File: rtl/strap_pkg.sv
// Shared encodings for the strap sampler.
// Assumes a two-bit line-rate code in which one value is illegal.
package strap_pkg;
    typedef logic [1:0] speed_t;
    localparam speed_t SPD_1G25  = 2'b00;
    localparam speed_t SPD_2G5   = 2'b01;
    localparam speed_t SPD_3G125 = 2'b10;
    localparam speed_t SPD_BAD   = 2'b11;
    localparam speed_t SPD_DEF   = SPD_3G125;

    // Reports whether a line-rate code names a supported rate.
    function automatic logic spd_legal(input speed_t code);
        return code != SPD_BAD;
    endfunction
endpackage

// File: rtl/strap_window.sv
// Stability window: counts consecutive rising edges at which the strap
// vector is unchanged and pulses capture when the run reaches STABLE.
// After that it freezes. Assumes STABLE >= 1.
module strap_window #(
    parameter int VECW   = 8,
    parameter int STABLE = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VECW-1:0] vec,
    output logic            capture,
    output logic            done
);
    localparam int CW = $clog2(STABLE + 1);

    logic [VECW-1:0] prev_q;
    logic [CW-1:0]   run_q;
    logic [CW-1:0]   run_nx;

    // Length of the run including the current edge.
    always_comb begin
        if (run_q == '0 || vec != prev_q) run_nx = CW'(1);
        else                              run_nx = run_q + CW'(1);
    end

    assign capture = !done && (run_nx == CW'(STABLE));

    // Track the run until capture, then hold everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            run_q  <= '0;
            done   <= 1'b0;
        end else if (!done) begin
            prev_q <= vec;
            run_q  <= run_nx;
            if (capture) done <= 1'b1;
        end
    end

    assert_run_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(STABLE));
    assert_capture_sets_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> done);
    assert_done_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
endmodule

// File: rtl/strap_speed.sv
// Line-rate register: loads the strap at capture, or a software value once
// frozen. Replaces the illegal code with the default and latches an error.
module strap_speed
    import strap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   capture,
    input  logic   done,
    input  speed_t strap_code,
    input  logic   wr_en,
    input  speed_t wr_code,
    output speed_t speed_q,
    output logic   err_q
);
    logic   load;
    speed_t src;

    // Pick the source of a load: the strap at capture, otherwise software.
    always_comb begin
        load = capture || (done && wr_en);
        src  = capture ? strap_code : wr_code;
    end

    // Store the code, falling back on illegal input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_q <= SPD_DEF;
            err_q   <= 1'b0;
        end else if (load) begin
            speed_q <= spd_legal(src) ? src : SPD_DEF;
            if (!spd_legal(src)) err_q <= 1'b1;
        end
    end

    assert_speed_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        speed_q != SPD_BAD);
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    assert_no_write_before_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !capture) |=> $stable(speed_q));
endmodule

// File: rtl/strap_pair_map.sv
// Per-pair decode: power coupling of the two ports and the lane index maps.
// Assumes the lower port of a pair is the one that can run four lanes.
module strap_pair_map #(
    parameter int LANES = 4,
    parameter int IDXW  = 2
) (
    input  logic                  split,
    input  logic                  pwr_lo,
    input  logic                  pwr_hi,
    input  logic                  tx_rev,
    input  logic                  rx_rev,
    output logic                  off_lo,
    output logic                  off_hi,
    output logic [LANES*IDXW-1:0] tx_map,
    output logic [LANES*IDXW-1:0] rx_map
);
    logic rx_rev_eff;

    // Power state: the upper port goes down with the lower one or when unused.
    always_comb begin
        off_lo     = pwr_lo;
        off_hi     = pwr_lo || pwr_hi || !split;
        rx_rev_eff = rx_rev && !split;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign tx_map[l*IDXW +: IDXW] = tx_rev     ? IDXW'(LANES-1-l) : IDXW'(l);
        assign rx_map[l*IDXW +: IDXW] = rx_rev_eff ? IDXW'(LANES-1-l) : IDXW'(l);
    end
endmodule

// File: rtl/strap_sampler.sv
// Reset-time strap sampler for a switch made of port pairs that can each
// run four lanes. It captures the straps after a stable window, freezes them,
// and decodes width, power, line rate and lane order. Software may later
// replace the line rate and the power-down requests. Reset is synchronous
// and active low.
module strap_sampler
    import strap_pkg::*;
#(
    parameter int NUM_PAIRS     = 2,
    parameter int LANES         = 4,
    parameter int STABLE_CYCLES = 10,
    localparam int NUM_PORTS    = 2 * NUM_PAIRS,
    localparam int IDXW         = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int MAPW         = NUM_PAIRS * LANES * IDXW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PAIRS-1:0] strap_split,
    input  logic [NUM_PORTS-1:0] strap_pwr,
    input  logic [1:0]           strap_speed,
    input  logic                 strap_tx_rev,
    input  logic                 strap_rx_rev,
    input  logic                 sw_speed_we,
    input  logic [1:0]           sw_speed,
    input  logic                 sw_pwr_we,
    input  logic [NUM_PORTS-1:0] sw_pwr,
    output logic                 cfg_valid,
    output logic [NUM_PAIRS-1:0] port_split,
    output logic [NUM_PORTS-1:0] port_off,
    output logic [1:0]           line_speed,
    output logic                 speed_err,
    output logic [MAPW-1:0]      tx_lane_map,
    output logic [MAPW-1:0]      rx_lane_map
);
    localparam int VECW = NUM_PAIRS + NUM_PORTS + 4;

    logic                 capture;
    logic                 done;
    logic [NUM_PAIRS-1:0] split_q;
    logic [NUM_PORTS-1:0] pwr_q;
    logic                 tx_rev_q;
    logic                 rx_rev_q;
    speed_t               speed_q;

    strap_window #(.VECW(VECW), .STABLE(STABLE_CYCLES)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .vec     ({strap_rx_rev, strap_tx_rev, strap_speed, strap_pwr, strap_split}),
        .capture (capture),
        .done    (done)
    );

    strap_speed u_speed (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .done       (done),
        .strap_code (strap_speed),
        .wr_en      (sw_speed_we),
        .wr_code    (sw_speed),
        .speed_q    (speed_q),
        .err_q      (speed_err)
    );

    // Hold the width and lane-order straps from capture on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            split_q  <= '0;
            tx_rev_q <= 1'b0;
            rx_rev_q <= 1'b0;
        end else if (capture) begin
            split_q  <= strap_split;
            tx_rev_q <= strap_tx_rev;
            rx_rev_q <= strap_rx_rev;
        end
    end

    // Power-down requests: strap at capture, software writes once frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)                pwr_q <= '1;
        else if (capture)          pwr_q <= strap_pwr;
        else if (done && sw_pwr_we) pwr_q <= sw_pwr;
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        strap_pair_map #(.LANES(LANES), .IDXW(IDXW)) u_map (
            .split  (split_q[p]),
            .pwr_lo (pwr_q[2*p]),
            .pwr_hi (pwr_q[2*p+1]),
            .tx_rev (tx_rev_q),
            .rx_rev (rx_rev_q),
            .off_lo (port_off[2*p]),
            .off_hi (port_off[2*p+1]),
            .tx_map (tx_lane_map[p*LANES*IDXW +: LANES*IDXW]),
            .rx_map (rx_lane_map[p*LANES*IDXW +: LANES*IDXW])
        );

        assert_wide_upper_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !port_split[p] |-> port_off[2*p+1]);
        assert_lower_drags_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
            port_off[2*p] |-> port_off[2*p+1]);
        assert_rx_ident_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
            port_split[p] |-> (rx_lane_map[p*LANES*IDXW +: IDXW] == '0));
    end

    assign cfg_valid  = done;
    assign port_split = split_q;
    assign line_speed = speed_q;

    assert_frozen_straps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> ($stable(port_split) && $stable(tx_lane_map) && $stable(rx_lane_map)));
    assert_pwr_no_early_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_valid && !capture) |=> $stable(port_off));
endmodule

// File: tb/strap_sampler_test.sv
module strap_sampler_test;
    localparam int NP = 2;
    localparam int NL = 4;
    localparam int NPORT = 2 * NP;
    localparam int IW = 2;
    localparam int MW = NP * NL * IW;
    localparam int STAB = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] strap_split = '0;
    logic [NPORT-1:0] strap_pwr = '0;
    logic [1:0] strap_speed = 2'b10;
    logic strap_tx_rev = 1'b0, strap_rx_rev = 1'b0;
    logic sw_speed_we = 1'b0, sw_pwr_we = 1'b0;
    logic [1:0] sw_speed = '0;
    logic [NPORT-1:0] sw_pwr = '0;
    logic cfg_valid, speed_err;
    logic [NP-1:0] port_split;
    logic [NPORT-1:0] port_off;
    logic [1:0] line_speed;
    logic [MW-1:0] tx_lane_map, rx_lane_map;

    int checks = 0;
    int failures = 0;
    bit cmp_on = 0;

    always #4 clk = ~clk;

    strap_sampler uut (
        .clk(clk), .rst_n(rst_n), .strap_split(strap_split), .strap_pwr(strap_pwr),
        .strap_speed(strap_speed), .strap_tx_rev(strap_tx_rev), .strap_rx_rev(strap_rx_rev),
        .sw_speed_we(sw_speed_we), .sw_speed(sw_speed), .sw_pwr_we(sw_pwr_we), .sw_pwr(sw_pwr),
        .cfg_valid(cfg_valid), .port_split(port_split), .port_off(port_off),
        .line_speed(line_speed), .speed_err(speed_err),
        .tx_lane_map(tx_lane_map), .rx_lane_map(rx_lane_map)
    );

    // Behavioural reference model, advanced at every rising edge.
    int m_run = 0;
    bit [31:0] m_prev = 0;
    bit m_done = 0, m_err = 0, m_tx = 0, m_rx = 0;
    bit [NP-1:0] m_split = 0;
    bit [NPORT-1:0] m_pwr = '1;
    bit [1:0] m_speed = 2'b10;

    function automatic bit [31:0] strap_word();
        return {strap_rx_rev, strap_tx_rev, strap_speed, strap_pwr, strap_split};
    endfunction

    function automatic void m_set_speed(bit [1:0] v);
        if (v == 2'b11) begin m_speed = 2'b10; m_err = 1; end
        else m_speed = v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_done = 0; m_err = 0; m_tx = 0; m_rx = 0;
            m_split = 0; m_pwr = '1; m_speed = 2'b10;
        end else if (!m_done) begin
            if (m_run == 0 || strap_word() != m_prev) m_run = 1;
            else m_run = m_run + 1;
            m_prev = strap_word();
            if (m_run == STAB) begin
                m_done = 1; m_split = strap_split; m_pwr = strap_pwr;
                m_tx = strap_tx_rev; m_rx = strap_rx_rev;
                m_set_speed(strap_speed);
            end
        end else begin
            if (sw_speed_we) m_set_speed(sw_speed);
            if (sw_pwr_we) m_pwr = sw_pwr;
        end
    end

    function automatic bit [NPORT-1:0] exp_off();
        bit [NPORT-1:0] r;
        for (int p = 0; p < NP; p++) begin
            r[2*p] = m_pwr[2*p];
            r[2*p+1] = m_pwr[2*p] | m_pwr[2*p+1] | !m_split[p];
        end
        return r;
    endfunction

    function automatic bit [MW-1:0] exp_map(bit rev, bit rx);
        bit [MW-1:0] r = '0;
        for (int p = 0; p < NP; p++)
            for (int l = 0; l < NL; l++) begin
                int idx = (rev && !(rx && m_split[p])) ? (NL - 1 - l) : l;
                r[(p*NL+l)*IW +: IW] = IW'(idx);
            end
        return r;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) if (cmp_on) begin
        chk("R1 cfg_valid", 64'(cfg_valid), 64'(m_done));
        chk("R3 port_split", 64'(port_split), 64'(m_split));
        chk("R4,R5 port_off", 64'(port_off), 64'(exp_off()));
        chk("R6 line_speed", 64'(line_speed), 64'(m_speed));
        chk("R6 speed_err", 64'(speed_err), 64'(m_err));
        chk("R7 tx_lane_map", 64'(tx_lane_map), 64'(exp_map(m_tx, 0)));
        chk("R8 rx_lane_map", 64'(rx_lane_map), 64'(exp_map(m_rx, 1)));
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        cyc(3);
        cmp_on = 1;
        // R10 reset state
        chk("R10 valid", 64'(cfg_valid), 0);
        chk("R10 off", 64'(port_off), 64'hF);
        chk("R10 speed", 64'(line_speed), 2);
        chk("R10 tx identity", 64'(tx_lane_map), 64'hE4E4);

        // Scenario A: pair0 four-lane, pair1 split, restart at edge 4.
        strap_split = 2'b10; strap_pwr = 4'b0100; strap_speed = 2'b01;
        strap_tx_rev = 1; strap_rx_rev = 1;
        sw_pwr_we = 1; sw_pwr = 4'b0000;       // R9 early write must be ignored
        rst_n = 1;
        cyc(4);
        sw_pwr_we = 0;
        strap_speed = 2'b00;                    // R1 restart
        cyc(9);
        chk("R1 not yet after edge 13", 64'(cfg_valid), 0);
        cyc(1);
        chk("R1 captured after edge 14", 64'(cfg_valid), 1);
        chk("R9 early pwr write ignored", 64'(port_off), 64'b1110);
        chk("R7 tx reversed", 64'(tx_lane_map), 64'h1B1B);
        chk("R8 rx: wide reversed, split identity", 64'(rx_lane_map), 64'hE41B);

        // R2 straps ignored after capture
        strap_split = 2'b01; strap_pwr = 4'b1111; strap_speed = 2'b11;
        strap_tx_rev = 0; strap_rx_rev = 0;
        cyc(3);
        chk("R2 split frozen", 64'(port_split), 64'b10);
        chk("R2 off frozen", 64'(port_off), 64'b1110);
        chk("R2 speed frozen", 64'(line_speed), 0);

        // R9 software overrides, R6 illegal write
        sw_speed_we = 1; sw_speed = 2'b01; cyc(1); sw_speed_we = 0;
        chk("R9 speed write", 64'(line_speed), 1);
        sw_speed_we = 1; sw_speed = 2'b11; cyc(1); sw_speed_we = 0;
        chk("R6 illegal write falls back", 64'(line_speed), 2);
        chk("R6 error flag", 64'(speed_err), 1);
        sw_pwr_we = 1; sw_pwr = 4'b1000; cyc(1); sw_pwr_we = 0;
        chk("R9 pwr write, R5 upper of wide pair", 64'(port_off), 64'b1010);
        sw_pwr_we = 1; sw_pwr = 4'b0001; cyc(1); sw_pwr_we = 0;
        chk("R4 lower drags upper", 64'(port_off), 64'b0011);
        cyc(2);
        chk("R6 error sticky", 64'(speed_err), 1);

        // Scenario B: all split, illegal strap speed, rx swap ignored.
        rst_n = 0; cyc(2);
        strap_split = 2'b11; strap_pwr = 4'b0010; strap_speed = 2'b11;
        strap_tx_rev = 0; strap_rx_rev = 1;
        rst_n = 1;
        cyc(9);
        chk("R1 not yet after edge 9", 64'(cfg_valid), 0);
        cyc(1);
        chk("R1 captured after edge 10", 64'(cfg_valid), 1);
        chk("R6 illegal strap", 64'(line_speed), 2);
        chk("R6 strap error", 64'(speed_err), 1);
        chk("R8 split identity", 64'(rx_lane_map), 64'hE4E4);
        chk("R4 upper own request", 64'(port_off), 64'b0010);

        // Scenario C: all wide, lower request down.
        rst_n = 0; cyc(2);
        chk("R10 err cleared", 64'(speed_err), 0);
        strap_split = 2'b00; strap_pwr = 4'b0001; strap_speed = 2'b00;
        strap_tx_rev = 0; strap_rx_rev = 1;
        rst_n = 1;
        cyc(12);
        chk("R3 all wide", 64'(port_split), 0);
        chk("R5 uppers off", 64'(port_off), 64'b1011);
        chk("R6 1.25 code", 64'(line_speed), 0);
        chk("R8 rx reversed wide", 64'(rx_lane_map), 64'h1B1B);
        cyc(2);
        summary();
    end
endmodule